// File: doc/BRIEF.md
# Accumulator Arithmetic and Status Flag Unit

This block is the arithmetic and condition-code stage of a small 8-bit accumulator processor. Each cycle it takes the accumulator, a memory operand and an operation code. It returns the result byte at once and writes the processor status byte on the next clock edge. It covers add with carry, subtract with borrow, compare, bit test, clearing the overflow flag, and loading the whole status byte from a data byte, as done when status is pulled from the stack or restored on an interrupt return.

The status register lives inside the block. Carry-in is taken from the stored carry bit. A separate active-low input lets external hardware force the overflow flag. That pin is synchronised to the clock, and a falling edge on it sets overflow even when an instruction writes the same flag in the same cycle. A signed less-than output comes from the stored flags. It gives the true sign of the last subtraction, which is still correct when the sign bit itself was corrupted by overflow.

Top module: `alu_flag_unit`

## Requirements
- R1: Add (op 0) returns acc + opnd + C as the result. Status bit 0 (C) takes the carry out of bit 7, bit 7 (N) takes result bit 7, and bit 1 (Z) is set when the result byte is zero.
- R2: On add, status bit 6 (V) is set only when both inputs have the same bit 7 and the result's bit 7 differs from it. Inputs of opposite sign always leave V clear.
- R3: Subtract (op 1) returns acc - opnd - (1 - C). C is set when no borrow occurred. V is set when the signed difference falls outside -128..127. N and Z follow the result byte.
- R4: Compare (op 2) ignores the stored carry. It sets C when opnd <= acc as unsigned values, sets Z when they are equal, and sets N to bit 7 of acc - opnd. It leaves V unchanged and returns acc as the result.
- R5: Bit test (op 3) sets Z when (acc AND opnd) is zero and copies opnd bits 7 and 6 into N and V. It leaves C unchanged and returns acc as the result.
- R6: Clear-overflow (op 4) clears V and leaves every other status bit unchanged.
- R7: Status load (op 5) replaces the status byte with opnd, except that bit 5 is forced to 1.
- R8: slt_o always equals status bit 7 XOR status bit 6.
- R9: A falling edge on so_n_i sets V at the third rising clock edge after the edge at which the low level first appears. Holding the pin low or raising it has no further effect.
- R10: When the pin-driven set and an instruction that writes V take effect at the same edge, V ends up 1 and the instruction's other flag writes still apply.
- R11: Status bit 5 always reads 1. When op_valid is low, or when op codes 6 or 7 are used, status is unchanged, and for op codes 6 and 7 the result equals acc.
- R12: A synchronous reset sets the status byte to 0x20, so slt_o reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is issued this cycle |
| op_sel | input | 3 | Operation code (0 add, 1 subtract, 2 compare, 3 bit test, 4 clear V, 5 status load) |
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Memory operand, or the byte to load into status |
| so_n_i | input | 1 | Asynchronous active-low external set-overflow request |
| result_o | output | 8 | Combinational result byte |
| status_o | output | 8 | Registered processor status byte |
| slt_o | output | 1 | Signed less-than, N XOR V |

## Verification
Two writers of V can land on the same clock edge: the synchronised falling edge of the external pin, and an instruction that writes V (clear-overflow or an add that clears V). The bench drops the pin at a known negative edge and counts forward three rising edges. It issues clear-overflow in the cycle the pin takes effect, and in another run an add of two small positives, and expects V set while C, N and Z still follow the add. Holding the pin low and then raising it are followed by clear-overflow operations that must take effect normally.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

    localparam int DW     = 8;
    localparam int MSB    = DW - 1;
    localparam int SB_C   = 0;
    localparam int SB_Z   = 1;
    localparam int SB_ONE = 5;
    localparam int SB_V   = 6;
    localparam int SB_N   = 7;
    localparam logic [DW-1:0] ST_RESET = DW'(1) << SB_ONE;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_CMP  = 3'd2,
        OP_TEST = 3'd3,
        OP_CLRV = 3'd4,
        OP_LDST = 3'd5
    } alu_op_e;

    typedef struct packed {
        logic [DW-1:0] val;
        logic [DW-1:0] wen;
    } flag_upd_t;

    function automatic logic all_zero(input logic [DW-1:0] x);
        return (x == '0);
    endfunction

endpackage

// File: rtl/alu_core.sv
module alu_core
    import alu_flag_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] opnd,
    input  logic          carry_in,
    output logic [DW-1:0] result,
    output flag_upd_t     upd
);

    logic [DW-1:0] addend;
    logic          cin;
    logic [DW:0]   sum;

    always_comb begin
        addend = (op == OP_ADD) ? opnd : ~opnd;
        cin    = (op == OP_CMP) ? 1'b1 : carry_in;
        sum    = {1'b0, acc} + {1'b0, addend} + {{DW{1'b0}}, cin};
    end

    always_comb begin
        upd    = '0;
        result = acc;
        unique case (op)
            OP_ADD, OP_SUB: begin
                result         = sum[MSB:0];
                upd.wen[SB_C]  = 1'b1;
                upd.wen[SB_Z]  = 1'b1;
                upd.wen[SB_N]  = 1'b1;
                upd.wen[SB_V]  = 1'b1;
                upd.val[SB_C]  = sum[DW];
                upd.val[SB_Z]  = all_zero(sum[MSB:0]);
                upd.val[SB_N]  = sum[MSB];
                upd.val[SB_V]  = (acc[MSB] == addend[MSB]) && (sum[MSB] != acc[MSB]);
            end
            OP_CMP: begin
                upd.wen[SB_C]  = 1'b1;
                upd.wen[SB_Z]  = 1'b1;
                upd.wen[SB_N]  = 1'b1;
                upd.val[SB_C]  = sum[DW];
                upd.val[SB_Z]  = all_zero(sum[MSB:0]);
                upd.val[SB_N]  = sum[MSB];
            end
            OP_TEST: begin
                upd.wen[SB_Z]  = 1'b1;
                upd.wen[SB_N]  = 1'b1;
                upd.wen[SB_V]  = 1'b1;
                upd.val[SB_Z]  = all_zero(acc & opnd);
                upd.val[SB_N]  = opnd[SB_N];
                upd.val[SB_V]  = opnd[SB_V];
            end
            OP_CLRV: begin
                upd.wen[SB_V]  = 1'b1;
                upd.val[SB_V]  = 1'b0;
            end
            OP_LDST: begin
                upd.wen        = '1;
                upd.val        = opnd;
            end
            default: begin
                upd = '0;
            end
        endcase
    end

endmodule

// File: rtl/so_pin_sync.sv
module so_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic fall
);

    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= {sh[STAGES-1:0], pin_n};
    end

    assign fall = sh[STAGES] & ~sh[STAGES-1];

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall);  // R9

endmodule

// File: rtl/status_reg.sv
module status_reg
    import alu_flag_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  flag_upd_t     upd,
    input  logic          set_v,
    output logic [DW-1:0] q
);

    logic [DW-1:0] nxt;

    for (genvar i = 0; i < DW; i++) begin : g_bit
        if (i == SB_ONE) begin : g_one
            assign nxt[i] = 1'b1;
        end else if (i == SB_V) begin : g_ovf
            assign nxt[i] = set_v | ((en && upd.wen[i]) ? upd.val[i] : q[i]);
        end else begin : g_plain
            assign nxt[i] = (en && upd.wen[i]) ? upd.val[i] : q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= ST_RESET;
        else     q <= nxt;
    end

    AST_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> q[SB_ONE]);  // R11

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
    import alu_flag_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       op_valid,
    input  logic [2:0] op_sel,
    input  logic [7:0] acc_i,
    input  logic [7:0] opnd_i,
    input  logic       so_n_i,
    output logic [7:0] result_o,
    output logic [7:0] status_o,
    output logic       slt_o
);

    alu_op_e   op;
    flag_upd_t upd;
    logic      so_fall;

    assign op = alu_op_e'(op_sel);

    alu_core u_core (
        .op       (op),
        .acc      (acc_i),
        .opnd     (opnd_i),
        .carry_in (status_o[SB_C]),
        .result   (result_o),
        .upd      (upd)
    );

    so_pin_sync #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .pin_n (so_n_i),
        .fall  (so_fall)
    );

    status_reg u_status (
        .clk   (clk),
        .rst   (rst),
        .en    (op_valid),
        .upd   (upd),
        .set_v (so_fall),
        .q     (status_o)
    );

    assign slt_o = status_o[SB_N] ^ status_o[SB_V];

    AST_ADD_MIXED_SIGN: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == 3'd0 && !so_fall && (acc_i[MSB] != opnd_i[MSB]))
        |=> !status_o[SB_V]);  // R2

    AST_CMP_KEEPS_V: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == 3'd2 && !so_fall)
        |=> status_o[SB_V] == $past(status_o[SB_V]));  // R4

    AST_TEST_COPIES: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == 3'd3 && !so_fall)
        |=> status_o[SB_N:SB_V] == $past(opnd_i[SB_N:SB_V]));  // R5

    AST_CLRV_ZERO: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == 3'd4 && !so_fall) |=> !status_o[SB_V]);  // R6

    AST_LOAD_STATUS: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == 3'd5 && !so_fall)
        |=> status_o == ($past(opnd_i) | ST_RESET));  // R7

    AST_PIN_WINS: assert property (@(posedge clk) disable iff (rst)
        so_fall |=> status_o[SB_V]);  // R10

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!op_valid && !so_fall) |=> $stable(status_o));  // R11

endmodule

// File: tb/alu_flag_unit_bench.sv
module alu_flag_unit_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0;
    logic [2:0] op_sel = 3'd0;
    logic [7:0] acc_i = 8'h00;
    logic [7:0] opnd_i = 8'h00;
    logic       so_n_i = 1'b1;
    logic [7:0] result_o;
    logic [7:0] status_o;
    logic       slt_o;

    always #10 clk = ~clk;

    alu_flag_unit u_alu_flag_unit (
        .clk      (clk),
        .rst      (rst),
        .op_valid (op_valid),
        .op_sel   (op_sel),
        .acc_i    (acc_i),
        .opnd_i   (opnd_i),
        .so_n_i   (so_n_i),
        .result_o (result_o),
        .status_o (status_o),
        .slt_o    (slt_o)
    );

    typedef struct {
        logic       chk_res;
        logic [7:0] res;
        logic [7:0] st;
        string      tag;
    } exp_t;

    exp_t       sb_q[$];
    int         checks = 0;
    int         fails  = 0;
    logic [7:0] mstat  = 8'h20;
    int         pin_pend = 0;
    bit         done = 0;

    function automatic void model(input logic [7:0] st, input logic [2:0] op,
                                  input logic [7:0] a, input logic [7:0] b,
                                  output logic [7:0] res, output logic [7:0] nst);
        int sa, sb, u, t, c;
        c   = int'(st[0]);
        sa  = a[7] ? int'(a) - 256 : int'(a);
        sb  = b[7] ? int'(b) - 256 : int'(b);
        nst = st;
        res = a;
        case (op)
            3'd0: begin
                u = int'(a) + int'(b) + c;  t = sa + sb + c;
                res = u[7:0];
                nst[0] = (u > 255); nst[6] = (t > 127) || (t < -128);
                nst[7] = res[7];    nst[1] = (res == 8'h00);
            end
            3'd1: begin
                u = int'(a) - int'(b) - (1 - c);  t = sa - sb - (1 - c);
                res = u[7:0];
                nst[0] = (u >= 0);  nst[6] = (t > 127) || (t < -128);
                nst[7] = res[7];    nst[1] = (res == 8'h00);
            end
            3'd2: begin
                u = int'(a) - int'(b);
                nst[0] = (b <= a); nst[1] = (a == b); nst[7] = u[7];
            end
            3'd3: begin
                nst[1] = ((a & b) == 8'h00); nst[7] = b[7]; nst[6] = b[6];
            end
            3'd4: nst[6] = 1'b0;
            3'd5: nst = b | 8'h20;
            default: nst = st;
        endcase
    endfunction

    task automatic step(input logic v, input logic [2:0] op, input logic [7:0] a,
                        input logic [7:0] b, input logic drop, input logic raise,
                        input string tag);
        exp_t e;
        logic [7:0] r, n;
        @(negedge clk);
        op_valid = v; op_sel = op; acc_i = a; opnd_i = b;
        if (drop)  begin so_n_i = 1'b0; pin_pend = 3; end
        if (raise) so_n_i = 1'b1;
        model(mstat, op, a, b, r, n);
        if (!v) n = mstat;
        if (pin_pend == 1) n[6] = 1'b1;
        if (pin_pend > 0) pin_pend--;
        e.chk_res = 1'b1; e.res = r; e.st = n; e.tag = tag;
        mstat = n;
        sb_q.push_back(e);
    endtask

    // monitor: result sampled mid low phase, status just after the edge
    initial begin
        forever begin
            logic [7:0] got_res;
            exp_t e;
            @(negedge clk);
            #5 got_res = result_o;
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                e = sb_q.pop_front();
                checks++;
                if (e.chk_res && got_res !== e.res) begin
                    fails++;
                    $display("FAIL %s result: got %h expected %h", e.tag, got_res, e.res);
                end else if (status_o !== e.st) begin
                    fails++;
                    $display("FAIL %s status: got %h expected %h", e.tag, status_o, e.st);
                end else if (slt_o !== (e.st[7] ^ e.st[6])) begin
                    fails++;
                    $display("FAIL R8 slt: got %b expected %b", slt_o, e.st[7] ^ e.st[6]);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #5;
        checks++;
        if (status_o !== 8'h20 || slt_o !== 1'b0) begin
            fails++;
            $display("FAIL R12 reset: got %h/%b expected 20/0", status_o, slt_o);
        end

        step(1, 3'd5, 8'h00, 8'h00, 0, 0, "R7 R11 load zero");
        step(1, 3'd5, 8'h00, 8'hDF, 0, 0, "R7 load all");
        step(1, 3'd4, 8'h33, 8'h00, 0, 0, "R6 clear V");
        step(0, 3'd5, 8'h00, 8'h00, 0, 0, "R11 idle");
        step(1, 3'd6, 8'h5A, 8'h00, 0, 0, "R11 code 6");
        step(1, 3'd7, 8'hA5, 8'h00, 0, 0, "R11 code 7");

        step(1, 3'd5, 8'h00, 8'h20, 0, 0, "R7 preload C0");
        step(1, 3'd2, 8'h40, 8'h40, 0, 0, "R4 equal, carry ignored");
        step(1, 3'd5, 8'h00, 8'h61, 0, 0, "R7 preload C1 V1");
        step(1, 3'd2, 8'h10, 8'h20, 0, 0, "R4 less, V kept");
        step(1, 3'd2, 8'hFF, 8'h00, 0, 0, "R4 greater");

        step(1, 3'd3, 8'h0F, 8'hC0, 0, 0, "R5 zero and copy");
        step(1, 3'd3, 8'h01, 8'h3F, 0, 0, "R5 nonzero");

        step(1, 3'd5, 8'h00, 8'h01, 0, 0, "R7 set C");
        step(1, 3'd1, 8'h80, 8'h01, 0, 0, "R3 R8 neg minus pos");
        step(1, 3'd5, 8'h00, 8'h01, 0, 0, "R7 set C");
        step(1, 3'd1, 8'h7F, 8'hFF, 0, 0, "R3 pos minus neg");
        step(1, 3'd5, 8'h00, 8'h00, 0, 0, "R7 clear C");
        step(1, 3'd0, 8'h7F, 8'h01, 0, 0, "R1 R2 positive overflow");
        step(1, 3'd0, 8'h80, 8'h80, 0, 0, "R1 R2 negative overflow");

        step(1, 3'd5, 8'h00, 8'h00, 1, 0, "R9 pin drop");
        step(0, 3'd0, 8'h00, 8'h00, 0, 0, "R9 wait");
        step(1, 3'd4, 8'h00, 8'h00, 0, 0, "R10 clear V same edge");
        step(0, 3'd0, 8'h00, 8'h00, 0, 0, "R9 held low");
        step(1, 3'd4, 8'h00, 8'h00, 0, 0, "R9 held low then clear");
        step(0, 3'd0, 8'h00, 8'h00, 0, 1, "R9 raise");
        step(0, 3'd0, 8'h00, 8'h00, 0, 0, "R9 after raise");
        step(0, 3'd0, 8'h00, 8'h00, 0, 0, "R9 after raise");
        step(1, 3'd4, 8'h00, 8'h00, 0, 0, "R6 R9 clear after raise");
        step(1, 3'd0, 8'h00, 8'h00, 1, 0, "R9 drop again");
        step(0, 3'd0, 8'h00, 8'h00, 0, 1, "R9 wait");
        step(1, 3'd0, 8'h01, 8'h01, 0, 0, "R10 add with pin");

        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++)
                step(1, 3'd0, a[7:0], b[7:0], 0, 0, "R1 R2 sweep");
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++)
                step(1, 3'd1, a[7:0], b[7:0], 0, 0, "R3 R8 sweep");

        step(0, 3'd0, 8'h00, 8'h00, 0, 0, "R11 final idle");
        repeat (3) @(posedge clk);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule